// File: doc/BRIEF.md
# Coin-Operated Parking Meter Timer

This block keeps track of how many minutes of parking remain. Three kinds of event drive it: a small coin, a large coin and a one-minute tick. A coin adds a fixed amount of time and a tick takes one minute away. The count never goes below zero and never goes above a configured maximum.

Each event arrives as a one-cycle strobe with a 2-bit code. One cycle after the event, the block raises a valid flag and reports whether parking is still safe or has expired. A cycle with no event is a stutter cycle. In a stutter cycle the count does not change, the valid flag is low, and the safe/expired flag keeps its last value.

The reset input is asynchronous and active-low. Inside the block it is released in step with the clock.

Top module: `parking_meter`

## Requirements
- R1: During reset and right after it, `out_valid` and `out_safe` are low and zero minutes remain. A tick as the first event therefore reports expired.
- R2: A small-coin event (code 01) adds SMALL_MIN minutes, 5 by default.
- R3: A large-coin event (code 10) adds LARGE_MIN minutes, 25 by default.
- R4: A tick event (code 00) removes one minute. `out_safe` is 1 when the count after the update is above zero, and 0 when it is zero.
- R5: A tick when zero minutes remain leaves the count at zero and reports expired (`out_safe` = 0).
- R6: The count saturates at MAX_MIN, 60 by default. A coin that would pass this limit sets the count to MAX_MIN.
- R7: The reserved code 11 behaves exactly like a tick.
- R8: A cycle with `ev_valid` low leaves the count unchanged. In the next cycle `out_valid` is 0 and `out_safe` holds its previous value.
- R9: `out_valid` is 1 in the cycle after every event, and `out_safe` shows the result of that event's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event present in this cycle |
| ev_code | input | 2 | Event code: 00 tick, 01 small coin, 10 large coin, 11 treated as tick |
| out_valid | output | 1 | Registered report valid, one cycle after an event |
| out_safe | output | 1 | 1 = safe (minutes remain), 0 = expired |

## Verification
Directed sequences tell the coin values apart by counting ticks:
- A small coin must stay safe for exactly four ticks and expire on the fifth.
- A large coin must stay safe for exactly twenty-four ticks and expire on the twenty-fifth.
- Three large coins followed by sixty ticks separate a saturating count from a wrapping or uncapped one.

Ticks at zero show the floor. The reserved code is checked against an ordinary tick. Random streams with frequent stutter cycles show that idle cycles neither move the count nor disturb the held flag. Throughout, a bench model tracks the minutes.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    EV_TICK  = 2'b00,
    EV_SMALL = 2'b01,
    EV_LARGE = 2'b10,
    EV_RSVD  = 2'b11
  } pm_event_e;
endpackage

// File: rtl/pm_decode.sv
module pm_decode
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  input  logic [1:0] ev_code,
  output logic       en_tick,
  output logic       en_small,
  output logic       en_large
);
  always_comb begin
    en_tick  = 1'b0;
    en_small = 1'b0;
    en_large = 1'b0;
    if (ev_valid) begin
      unique case (pm_event_e'(ev_code))
        EV_SMALL: en_small = 1'b1;
        EV_LARGE: en_large = 1'b1;
        default:  en_tick  = 1'b1;  // tick and reserved (R7)
      endcase
    end
  end

  // R8/R9: exactly one action per event, none without one
  p_one_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $onehot({en_tick, en_small, en_large}));
  p_no_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |-> ({en_tick, en_small, en_large} == 3'b000));
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int SMALL_MIN = 5,
  parameter int LARGE_MIN = 25,
  parameter int MAX_MIN   = 60,
  parameter int W         = $clog2(MAX_MIN + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_tick,
  input  logic         en_small,
  input  logic         en_large,
  output logic [W-1:0] count_q,
  output logic [W-1:0] count_d
);
  localparam int SW = W + 1;
  localparam logic [SW-1:0] MAX_S   = SW'(MAX_MIN);
  localparam logic [SW-1:0] SMALL_S = SW'(SMALL_MIN);
  localparam logic [SW-1:0] LARGE_S = SW'(LARGE_MIN);

  logic [SW-1:0] sum;
  logic          en_any;

  assign en_any = en_tick | en_small | en_large;

  always_comb begin
    sum     = {1'b0, count_q} + (en_large ? LARGE_S : SMALL_S);
    count_d = count_q;
    if (en_small || en_large) begin
      count_d = (sum > MAX_S) ? MAX_S[W-1:0] : sum[W-1:0];
    end else if (en_tick) begin
      count_d = (count_q == '0) ? '0 : count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (en_any) count_q <= count_d;
  end

  p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_any |=> ({1'b0, count_q} <= MAX_S));
  p_tick_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_tick && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));
  p_tick_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_tick && count_q == '0) |=> (count_q == '0));
  p_stutter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_any |=> $stable(count_q));
endmodule

// File: rtl/pm_report.sv
module pm_report #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_valid,
  input  logic [W-1:0] count_d,
  output logic         out_valid,
  output logic         out_safe
);
  logic safe_d;

  always_comb begin
    safe_d = out_safe;
    if (ev_valid) safe_d = (count_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_safe  <= 1'b0;
    end else begin
      out_valid <= ev_valid;
      out_safe  <= safe_d;
    end
  end

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> out_valid);
  p_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> (!out_valid && $stable(out_safe)));
endmodule

// File: rtl/parking_meter.sv
module parking_meter #(
  parameter int SMALL_MIN = 5,
  parameter int LARGE_MIN = 25,
  parameter int MAX_MIN   = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  input  logic [1:0] ev_code,
  output logic       out_valid,
  output logic       out_safe
);
  localparam int W = $clog2(MAX_MIN + 1);

  logic [1:0]   rst_sync;
  logic         rst_n_s;
  logic         en_tick, en_small, en_large;
  logic [W-1:0] count_q, count_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  pm_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ev_valid (ev_valid),
    .ev_code  (ev_code),
    .en_tick  (en_tick),
    .en_small (en_small),
    .en_large (en_large)
  );

  pm_counter #(
    .SMALL_MIN (SMALL_MIN),
    .LARGE_MIN (LARGE_MIN),
    .MAX_MIN   (MAX_MIN),
    .W         (W)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .en_tick  (en_tick),
    .en_small (en_small),
    .en_large (en_large),
    .count_q  (count_q),
    .count_d  (count_d)
  );

  pm_report #(.W(W)) u_report (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ev_valid  (ev_valid),
    .count_d   (count_d),
    .out_valid (out_valid),
    .out_safe  (out_safe)
  );

  // R1: nothing reported while held in reset
  always_comb begin
    if (!rst_n_s) p_reset_quiet_r1: assert (!out_valid || $isunknown(out_valid));
  end
endmodule

// File: tb/parking_meter_tb.sv
module parking_meter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SMALL = 5;
  localparam int LARGE = 25;
  localparam int MAXM  = 60;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ev_valid;
  logic [1:0] ev_code;
  logic       out_valid;
  logic       out_safe;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parking_meter u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .out_valid(out_valid), .out_safe(out_safe)
  );

  function automatic int next_minutes(int m, bit v, logic [1:0] c);
    int r;
    if (!v) return m;
    case (c)
      2'b01:   r = m + SMALL;
      2'b10:   r = m + LARGE;
      default: r = (m == 0) ? 0 : m - 1;
    endcase
    return (r > MAXM) ? MAXM : r;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the next negedge after the edge
  task automatic step(bit v, logic [1:0] c, string req);
    logic prev_safe;
    prev_safe = out_safe;
    ev_valid = v;
    ev_code  = c;
    @(posedge clk);
    @(negedge clk);
    model = next_minutes(model, v, c);
    check(req, out_valid, v);
    if (v) check(req, out_safe, model > 0);
    else   check(req, out_safe, prev_safe);
    ev_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; ev_valid = 1'b0; ev_code = 2'b00;
    repeat (3) @(negedge clk);
    check("R1", out_valid, 1'b0);
    check("R1", out_safe, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", out_valid, 1'b0);
    step(1, 2'b00, "R1");                  // first tick after reset: expired
    step(1, 2'b00, "R5");                  // tick at zero stays expired
    step(1, 2'b01, "R2");
    for (int i = 0; i < 4; i++) step(1, 2'b00, "R2");
    step(1, 2'b00, "R4");                  // fifth tick expires
    step(1, 2'b10, "R3");
    step(0, 2'b01, "R8");                  // stutter with a coin code
    for (int i = 0; i < 25; i++) step(1, 2'b00, "R3");
    step(1, 2'b11, "R5");
    step(1, 2'b01, "R7");
    for (int i = 0; i < 4; i++) step(1, 2'b11, "R7");
    step(1, 2'b11, "R7");
    for (int i = 0; i < 3; i++) step(1, 2'b10, "R6");
    step(1, 2'b01, "R6");
    for (int i = 0; i < 59; i++) step(1, 2'b00, "R6");
    step(1, 2'b00, "R6");
    step(0, 2'b10, "R8");
    step(1, 2'b00, "R5");
    for (int i = 0; i < 3000; i++) begin
      bit v;
      logic [1:0] c;
      int r;
      v = ($urandom_range(0, 3) != 0);
      r = $urandom_range(0, 15);
      c = (r == 0) ? 2'b10 : (r < 3) ? 2'b01 : (r == 3) ? 2'b11 : 2'b00;
      step(v, c, v ? "R9" : "R8");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule